// File: doc/BRIEF.md
# Network Interrupt Status and Mask Register

This block gathers the eight interrupt causes of a network controller into one 16-bit host-visible word. The low byte shows the cause flags and the high byte holds the per-cause enable bits, aligned bit for bit with the flags. A single interrupt line is raised while any enabled flag is set.

There are two kinds of flag. Event flags catch single-cycle pulses from the MAC, PHY and buffer unit, and they hold until software writes a one to them. Level flags show live FIFO conditions and cannot be cleared by a write: the receive flag stays up while the receive FIFO is not empty, and the transmit-empty flag stays up while the transmit FIFO is empty. The early-receive flag is generated inside the block. It is set when the running received byte count first rises above a threshold that software programs.

A two-bit byte enable on host writes lets software update the enable byte and acknowledge flags in separate accesses, or in the same access.

Top module: `net_irq_hub`

## Requirements
- R1: After reset all event flags and all enable bits read 0, and `irq_out` is 0 while both level inputs are 0.
- R2: A one-cycle pulse on an event input sets its flag at the next clock edge. The flag positions are: bit 7 PHY state change, bit 5 protocol event, bit 4 receive overrun, bit 3 allocation complete, bit 1 transmit done.
- R3: A host write with `host_be[1]`=1 loads `host_wdata[15:8]` into the enable byte at bits 15:8 at the clock edge.
- R4: `irq_out` is 1 exactly when some bit in 7:0 of the read word is 1 and the enable bit 8 places above it is also 1.
- R5: A host write with `host_be[0]`=1 clears, at that edge, each event flag whose `host_wdata` bit is 1. Flags written with 0 keep their value.
- R6: When an event pulse and a write-one acknowledge of the same flag fall in the same cycle, the flag is 1 after the edge.
- R7: Bit 0 equals `rx_nempty` and bit 2 equals `tx_empty` at all times. Writing ones to these bits has no effect.
- R8: Bit 6 (early receive) is set at the first edge where `rx_byte_cnt` > `erx_thresh` after an edge where it was not. Once it has been acknowledged, it does not set again until the count has fallen back to the threshold or below and then risen above it.
- R9: With `host_be[0]`=0 a write acknowledges nothing. With `host_be[1]`=0 a write leaves the enable byte unchanged.
- R10: `host_rdata` is {enable byte, flag byte} at all times, so a write with both byte enables updates both halves in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_be | input | 2 | Byte enables: [0] acknowledge byte, [1] enable byte |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read word {enable byte, flag byte} |
| phy_chg | input | 1 | PHY state change pulse |
| prot_evt | input | 1 | Protocol event pulse |
| rx_ovrn | input | 1 | Receive overrun pulse |
| alloc_done | input | 1 | Allocation complete pulse |
| tx_done | input | 1 | Transmit done/error pulse |
| rx_nempty | input | 1 | Receive FIFO not empty level |
| tx_empty | input | 1 | Transmit FIFO empty level |
| rx_byte_cnt | input | CNT_W | Running received byte count |
| erx_thresh | input | CNT_W | Early-receive threshold |
| irq_out | output | 1 | Interrupt request |

## Verification
The collision that matters is an event pulse arriving in the same cycle as a host acknowledge of that flag. The bench writes a one to every flag while it pulses allocation-complete, and expects only that flag to survive. A second overlap writes the enable byte and acknowledges flags in one access while a protocol event arrives, and `irq_out` is judged against the new enable byte together with the surviving flag. Level flags are also written with ones while their inputs are high, and the bench expects the read word to be unchanged.

// File: rtl/net_irq_pkg.sv
package net_irq_pkg;
   localparam int STAT_W = 8;
   localparam int WORD_W = 2 * STAT_W;

   localparam int B_RXPKT   = 0;
   localparam int B_TXDONE  = 1;
   localparam int B_TXEMPTY = 2;
   localparam int B_ALLOC   = 3;
   localparam int B_OVRN    = 4;
   localparam int B_PROT    = 5;
   localparam int B_EARLY   = 6;
   localparam int B_PHY     = 7;

   // bits that mirror a live level instead of latching a pulse
   localparam logic [STAT_W-1:0] LEVEL_DEFAULT = 8'h05;

   typedef struct packed {
      logic [STAT_W-1:0] enable;
      logic [STAT_W-1:0] flags;
   } irq_word_t;
endpackage

// File: rtl/net_irq_cross.sv
// Rising-crossing detector: pulses once when count first exceeds threshold.
module net_irq_cross #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] thresh,
   output logic             fire
);
   logic above;
   logic above_q;

   assign above = (count > thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) above_q <= 1'b0;
      else        above_q <= above;
   end

   assign fire = above & ~above_q;
endmodule

// File: rtl/net_irq_mask.sv
module net_irq_mask #(
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [STAT_W-1:0] wdata,
   output logic [STAT_W-1:0] enable
);
   logic [STAT_W-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  en_q <= '0;
      else if (we) en_q <= wdata;
   end

   assign enable = en_q;
endmodule

// File: rtl/net_irq_status.sv
// Per-bit flag cells: level bits mirror their input, the rest are sticky
// with write-one-to-clear; a new pulse beats a simultaneous clear.
module net_irq_status #(
   parameter int                STAT_W    = 8,
   parameter logic [STAT_W-1:0] LEVEL_SEL = 8'h05
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] src,
   input  logic [STAT_W-1:0] ack,
   output logic [STAT_W-1:0] flags
);
   logic lvl_ack_unused;
   assign lvl_ack_unused = ^(ack & LEVEL_SEL);

   for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      if (LEVEL_SEL[i]) begin : g_lvl
         assign flags[i] = src[i];
      end else begin : g_lat
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= src[i] | (q & ~ack[i]);
         end
         assign flags[i] = q;
      end
   end
endmodule

// File: rtl/net_irq_hub.sv
module net_irq_hub
   import net_irq_pkg::*;
#(
   parameter int                CNT_W     = 11,
   parameter logic [STAT_W-1:0] LEVEL_SEL = LEVEL_DEFAULT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [1:0]        host_be,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   input  logic              phy_chg,
   input  logic              prot_evt,
   input  logic              rx_ovrn,
   input  logic              alloc_done,
   input  logic              tx_done,
   input  logic              rx_nempty,
   input  logic              tx_empty,
   input  logic [CNT_W-1:0]  rx_byte_cnt,
   input  logic [CNT_W-1:0]  erx_thresh,
   output logic              irq_out
);
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("net_irq_hub: CNT_W out of range");
   end
   if (LEVEL_SEL[B_EARLY]) begin : g_bad_level_sel
      $error("net_irq_hub: early-receive bit must be an event bit");
   end

   logic              erx_fire;
   logic [STAT_W-1:0] src;
   logic [STAT_W-1:0] ack;
   logic              en_we;
   logic [STAT_W-1:0] flags;
   logic [STAT_W-1:0] enable;
   irq_word_t         word;

   net_irq_cross #(.CNT_W(CNT_W)) u_erx (
      .clk    (clk),
      .rst_n  (rst_n),
      .count  (rx_byte_cnt),
      .thresh (erx_thresh),
      .fire   (erx_fire)
   );

   always_comb begin
      src            = '0;
      src[B_RXPKT]   = rx_nempty;
      src[B_TXDONE]  = tx_done;
      src[B_TXEMPTY] = tx_empty;
      src[B_ALLOC]   = alloc_done;
      src[B_OVRN]    = rx_ovrn;
      src[B_PROT]    = prot_evt;
      src[B_EARLY]   = erx_fire;
      src[B_PHY]     = phy_chg;
   end

   assign ack   = {STAT_W{host_wr & host_be[0]}} & host_wdata[STAT_W-1:0];
   assign en_we = host_wr & host_be[1];

   net_irq_status #(.STAT_W(STAT_W), .LEVEL_SEL(LEVEL_SEL)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src),
      .ack   (ack),
      .flags (flags)
   );

   net_irq_mask #(.STAT_W(STAT_W)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (en_we),
      .wdata  (host_wdata[WORD_W-1:STAT_W]),
      .enable (enable)
   );

   assign word.flags  = flags;
   assign word.enable = enable;
   assign host_rdata  = word;
   assign irq_out     = |(flags & enable);
endmodule

// File: rtl/net_irq_hub_chk.sv
module net_irq_hub_chk
   import net_irq_pkg::*;
#(
   parameter int                CNT_W     = 11,
   parameter logic [STAT_W-1:0] LEVEL_SEL = LEVEL_DEFAULT
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic [1:0]        host_be,
   input logic [WORD_W-1:0] host_wdata,
   input logic [WORD_W-1:0] host_rdata,
   input logic              phy_chg,
   input logic              prot_evt,
   input logic              rx_ovrn,
   input logic              alloc_done,
   input logic              tx_done,
   input logic              rx_nempty,
   input logic              tx_empty,
   input logic [CNT_W-1:0]  rx_byte_cnt,
   input logic [CNT_W-1:0]  erx_thresh,
   input logic              irq_out
);
   localparam logic [STAT_W-1:0] EARLY_M = STAT_W'(1) << B_EARLY;
   localparam logic [STAT_W-1:0] EVT_M   = ~LEVEL_SEL & ~EARLY_M;

   logic [STAT_W-1:0] src_v;
   logic [STAT_W-1:0] ack_v;

   always_comb begin
      src_v            = '0;
      src_v[B_RXPKT]   = rx_nempty;
      src_v[B_TXDONE]  = tx_done;
      src_v[B_TXEMPTY] = tx_empty;
      src_v[B_ALLOC]   = alloc_done;
      src_v[B_OVRN]    = rx_ovrn;
      src_v[B_PROT]    = prot_evt;
      src_v[B_PHY]     = phy_chg;
   end
   assign ack_v = {STAT_W{host_wr & host_be[0]}} & host_wdata[STAT_W-1:0];

   assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((host_rdata[STAT_W-1:0] & $past(src_v & EVT_M)) == $past(src_v & EVT_M)));

   assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((host_rdata[STAT_W-1:0] & $past(ack_v & ~src_v & EVT_M)) == '0));

   assert_evt_beats_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((host_rdata[STAT_W-1:0] & $past(ack_v & src_v & EVT_M)) == $past(ack_v & src_v & EVT_M)));

   assert_level_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((host_rdata[STAT_W-1:0] ^ src_v) & LEVEL_SEL) == '0);

   assert_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == |(host_rdata[STAT_W-1:0] & host_rdata[WORD_W-1:STAT_W]));

   assert_mask_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_be[1]) |=> (host_rdata[WORD_W-1:STAT_W] == $past(host_wdata[WORD_W-1:STAT_W])));

   assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && host_be[1]) |=> $stable(host_rdata[WORD_W-1:STAT_W]));

   assert_early_cross_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_rdata[B_EARLY]) |-> ($past(rx_byte_cnt) > $past(erx_thresh)));
endmodule

bind net_irq_hub net_irq_hub_chk #(.CNT_W(CNT_W), .LEVEL_SEL(LEVEL_SEL)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_wr     (host_wr),
   .host_be     (host_be),
   .host_wdata  (host_wdata),
   .host_rdata  (host_rdata),
   .phy_chg     (phy_chg),
   .prot_evt    (prot_evt),
   .rx_ovrn     (rx_ovrn),
   .alloc_done  (alloc_done),
   .tx_done     (tx_done),
   .rx_nempty   (rx_nempty),
   .tx_empty    (tx_empty),
   .rx_byte_cnt (rx_byte_cnt),
   .erx_thresh  (erx_thresh),
   .irq_out     (irq_out)
);

// File: tb/net_irq_hub_bench.sv
module net_irq_hub_bench;
   localparam int CLK_P = 10;
   localparam int CNT_W = 11;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             host_wr = 1'b0;
   logic [1:0]       host_be = 2'b00;
   logic [15:0]      host_wdata = 16'h0;
   logic [15:0]      host_rdata;
   logic             phy_chg = 1'b0, prot_evt = 1'b0, rx_ovrn = 1'b0;
   logic             alloc_done = 1'b0, tx_done = 1'b0;
   logic             rx_nempty = 1'b0, tx_empty = 1'b0;
   logic [CNT_W-1:0] rx_byte_cnt = '0;
   logic [CNT_W-1:0] erx_thresh = CNT_W'(100);
   logic             irq_out;

   int n_chk = 0;
   int n_bad = 0;

   logic [15:0] q_data[$];
   logic        q_irq[$];
   string       q_tag[$];

   // requirement-derived model state
   logic [7:0] m_lat = 8'h00;
   logic [7:0] m_en  = 8'h00;
   bit         m_above = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   net_irq_hub #(.CNT_W(CNT_W)) u_net_irq_hub (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_be(host_be),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .phy_chg(phy_chg), .prot_evt(prot_evt), .rx_ovrn(rx_ovrn),
      .alloc_done(alloc_done), .tx_done(tx_done),
      .rx_nempty(rx_nempty), .tx_empty(tx_empty),
      .rx_byte_cnt(rx_byte_cnt), .erx_thresh(erx_thresh), .irq_out(irq_out)
   );

   // driver: one host/source cycle, expected result pushed to the scoreboard
   // ev layout: 7 PHY, 5 protocol, 4 overrun, 3 alloc, 1 tx done
   task automatic apply(input string tag, input bit wr, input bit [1:0] be,
                        input bit [15:0] wd, input bit [7:0] ev,
                        input bit rxne, input bit txe, input int cnt);
      bit [7:0] ack, evts, lvl, st;
      bit       above, fire;
      @(negedge clk);
      host_wr = wr; host_be = be; host_wdata = wd;
      phy_chg = ev[7]; prot_evt = ev[5]; rx_ovrn = ev[4];
      alloc_done = ev[3]; tx_done = ev[1];
      rx_nempty = rxne; tx_empty = txe;
      rx_byte_cnt = CNT_W'(cnt);
      above = (cnt > int'(erx_thresh));
      fire  = above && !m_above;
      m_above = above;
      ack  = (wr && be[0]) ? wd[7:0] : 8'h00;
      evts = (ev & 8'hBA) | (fire ? 8'h40 : 8'h00);
      m_lat = (evts | (m_lat & ~ack)) & 8'hFA;
      if (wr && be[1]) m_en = wd[15:8];
      lvl = {5'b0, txe, 1'b0, rxne};
      st  = m_lat | lvl;
      q_data.push_back({m_en, st});
      q_irq.push_back(|(st & m_en));
      q_tag.push_back(tag);
   endtask

   // monitor: compare after each edge, while inputs are still held
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q_data.size() > 0) begin
            logic [15:0] ed;
            logic        ei;
            string       tg;
            ed = q_data.pop_front();
            ei = q_irq.pop_front();
            tg = q_tag.pop_front();
            n_chk++;
            if (host_rdata !== ed || irq_out !== ei) begin
               n_bad++;
               $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                        tg, host_rdata, irq_out, ed, ei);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      n_chk++;
      if (host_rdata !== 16'h0000 || irq_out !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: rdata=%h irq=%b expected rdata=0000 irq=0", host_rdata, irq_out);
      end
      apply("R3", 1, 2'b10, 16'hFF00, 8'h00, 0, 0, 0);  // enable all
      apply("R2", 0, 2'b00, 16'h0000, 8'h80, 0, 0, 0);  // PHY change
      apply("R2", 0, 2'b00, 16'h0000, 8'h3A, 0, 0, 0);  // other events
      apply("R5", 1, 2'b01, 16'h0080, 8'h00, 0, 0, 0);  // clear bit 7 only
      apply("R9", 1, 2'b10, 16'h0F3A, 8'h00, 0, 0, 0);  // no ack without be[0]
      apply("R9", 1, 2'b00, 16'hFFFF, 8'h00, 0, 0, 0);  // no effect at all
      apply("R6", 1, 2'b01, 16'h00FF, 8'h08, 0, 0, 0);  // event beats ack
      apply("R7", 0, 2'b00, 16'h0000, 8'h00, 1, 1, 0);  // levels appear
      apply("R7", 1, 2'b01, 16'h0005, 8'h00, 1, 1, 0);  // writing ones ignored
      apply("R5", 1, 2'b01, 16'h0008, 8'h00, 0, 0, 0);
      apply("R4", 1, 2'b10, 16'h4000, 8'h00, 0, 0, 0);  // enable early only
      apply("R8", 0, 2'b00, 16'h0000, 8'h00, 0, 0, 100); // equal: no fire
      apply("R8", 0, 2'b00, 16'h0000, 8'h00, 0, 0, 101); // crosses
      apply("R8", 1, 2'b01, 16'h0040, 8'h00, 0, 0, 150); // ack, still above
      apply("R8", 0, 2'b00, 16'h0000, 8'h00, 0, 0, 150); // no refire
      apply("R8", 0, 2'b00, 16'h0000, 8'h00, 0, 0, 90);
      apply("R8", 0, 2'b00, 16'h0000, 8'h00, 0, 0, 200); // re-crosses
      apply("R10", 1, 2'b11, 16'hA540, 8'h20, 0, 0, 200); // both bytes + event
      apply("R4", 0, 2'b00, 16'h0000, 8'h00, 0, 0, 200);
      @(negedge clk);
      host_wr = 1'b0;
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule